// File: doc/BRIEF.md
# Set-associative cache hit/miss tracker

This block models the lookup behaviour of a set-associative cache without holding any cached data. Each address offered on the request port is split into a tag, a set index and a block offset. Only the tag and the set index are used. The selected set is searched across all its ways at once, and the access is classified as a hit, a miss that fills an empty line, or a miss that evicts a resident line. The tag store is then updated so that the next access sees the new contents.

Replacement uses a small age counter on every line. Each access to a set ages every line of that set by one, and the line that was hit or filled drops back to zero. On a miss the lowest empty way is used first. Only when the set is full is the oldest line evicted. Running totals of hits, misses and evictions let an external model compare its own statistics with those of the hardware. With one way per set the block is a direct-mapped tracker.

Top module: `cache_hit_tracker`

## Requirements
- R1: An address splits, from most to least significant bit, into a tag of ADDR_W − SET_BITS − OFFSET_BITS bits, a set index of SET_BITS bits and a block offset of OFFSET_BITS bits. The set index is read as an unsigned number selecting one of 2^SET_BITS sets, and the offset has no effect on any result.
- R2: An access is a hit exactly when some line of the selected set is valid and holds a tag equal to the address tag.
- R3: A miss in a set that still has an invalid line writes the tag into the lowest-numbered invalid way, sets it valid and reports no eviction.
- R4: A miss reports an eviction only when every line of the selected set is valid. Eviction implies miss, and exactly one of hit or miss is set on each result.
- R5: Every access to a set increments the age of every line in that set, saturating at 2^AGE_W − 1, and then sets the age of the line that hit or was written to zero. Other sets are not touched.
- R6: An eviction replaces the line with the largest age in the set, the lowest-numbered way winning a tie, and stores the new tag there as valid.
- R7: With WAYS = 1 every miss on a valid line replaces that line and reports an eviction.
- R8: The request port is always ready. Each accepted request yields exactly one result with rsp_valid_o high on the following cycle. In any other cycle rsp_valid_o and all three flags are low.
- R9: Reset clears all valid bits, all ages, all three counters and the result outputs, so the first access to any set after reset is a miss without eviction.
- R10: The hit, miss and eviction counters each rise by one in the same cycle as a result carrying that flag, and hold otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Access request present |
| req_ready_o | output | 1 | Request accepted (always high) |
| req_addr_i | input | ADDR_W | Access address |
| rsp_valid_o | output | 1 | Result present |
| rsp_hit_o | output | 1 | Access hit |
| rsp_miss_o | output | 1 | Access missed |
| rsp_evict_o | output | 1 | Miss replaced a valid line |
| hit_count_o | output | CNT_W | Total hits |
| miss_count_o | output | CNT_W | Total misses |
| evict_count_o | output | CNT_W | Total evictions |

## Verification
The bench builds two copies side by side, both with a 16-bit address, four sets and a 4-bit offset. One has four ways and 3-bit ages, so a set fills, evicts and reaches age saturation within about a dozen accesses, and a tie between saturated lines can be provoked on purpose. The other has one way, which brings the direct-mapped replacement into reach with the same address stream. Random addresses drawn from a small pool of tags keep hits, fills and evictions all frequent, and idle cycles between requests check that results appear only when a request was accepted.

// File: rtl/cht_pkg.sv
package cht_pkg;

  typedef struct packed {
    logic hit;
    logic miss;
    logic evict;
  } cht_result_t;

endpackage

// File: rtl/cht_addr_split.sv
module cht_addr_split #(
  parameter int ADDR_W      = 16,
  parameter int SET_BITS    = 2,
  parameter int OFFSET_BITS = 4,
  localparam int TAG_W      = ADDR_W - SET_BITS - OFFSET_BITS
) (
  input  logic [ADDR_W-1:0]   addr_i,
  output logic [TAG_W-1:0]    tag_o,
  output logic [SET_BITS-1:0] set_o
);

  assign tag_o = addr_i[ADDR_W-1 -: TAG_W];
  assign set_o = addr_i[OFFSET_BITS +: SET_BITS];

  // offset bits are deliberately dropped
  logic unused_offset;
  assign unused_offset = ^addr_i[OFFSET_BITS-1:0];

endmodule

// File: rtl/cht_way_select.sv
module cht_way_select
  import cht_pkg::*;
#(
  parameter int WAYS      = 4,
  parameter int TAG_W     = 10,
  parameter int AGE_W     = 3,
  localparam int WAY_IDX_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-1:0]            valid_i,
  input  logic [WAYS-1:0][TAG_W-1:0] tag_i,
  input  logic [WAYS-1:0][AGE_W-1:0] age_i,
  input  logic [TAG_W-1:0]           key_i,
  output logic [WAY_IDX_W-1:0]       target_o,
  output cht_result_t                result_o
);

  logic [WAYS-1:0]      hit_vec;
  logic [WAY_IDX_W-1:0] hit_way;
  logic [WAY_IDX_W-1:0] free_way;
  logic [WAY_IDX_W-1:0] old_way;
  logic [AGE_W-1:0]     old_age;
  logic                 any_hit;
  logic                 any_free;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = valid_i[w] && (tag_i[w] == key_i);
  end

  assign any_hit  = |hit_vec;
  assign any_free = ~&valid_i;

  // descending scan: last assignment is the lowest way
  always_comb begin
    hit_way  = '0;
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hit_vec[w])  hit_way  = WAY_IDX_W'(w);
      if (!valid_i[w]) free_way = WAY_IDX_W'(w);
    end
  end

  // ascending scan with strict compare keeps lowest way on ties
  always_comb begin
    old_way = '0;
    old_age = age_i[0];
    for (int w = 1; w < WAYS; w++) begin
      if (age_i[w] > old_age) begin
        old_way = WAY_IDX_W'(w);
        old_age = age_i[w];
      end
    end
  end

  always_comb begin
    if (any_hit)       target_o = hit_way;
    else if (any_free) target_o = free_way;
    else               target_o = old_way;
  end

  assign result_o.hit   = any_hit;
  assign result_o.miss  = ~any_hit;
  assign result_o.evict = ~any_hit & ~any_free;

endmodule

// File: rtl/cht_line_store.sv
module cht_line_store #(
  parameter int SET_BITS  = 2,
  parameter int WAYS      = 4,
  parameter int TAG_W     = 10,
  parameter int AGE_W     = 3,
  localparam int NUM_SETS  = 1 << SET_BITS,
  localparam int WAY_IDX_W = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam logic [AGE_W-1:0] AGE_MAX = {AGE_W{1'b1}}
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [SET_BITS-1:0]        set_i,
  output logic [WAYS-1:0]            rd_valid_o,
  output logic [WAYS-1:0][TAG_W-1:0] rd_tag_o,
  output logic [WAYS-1:0][AGE_W-1:0] rd_age_o,
  input  logic                       upd_i,
  input  logic [WAY_IDX_W-1:0]       upd_way_i,
  input  logic [TAG_W-1:0]           upd_tag_i
);

  logic             valid_q [NUM_SETS][WAYS];
  logic [TAG_W-1:0] tag_q   [NUM_SETS][WAYS];
  logic [AGE_W-1:0] age_q   [NUM_SETS][WAYS];

  for (genvar w = 0; w < WAYS; w++) begin : g_rd
    assign rd_valid_o[w] = valid_q[set_i][w];
    assign rd_tag_o[w]   = tag_q[set_i][w];
    assign rd_age_o[w]   = age_q[set_i][w];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < NUM_SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          valid_q[s][w] <= 1'b0;
          tag_q[s][w]   <= '0;
          age_q[s][w]   <= '0;
        end
      end
    end else if (upd_i) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_IDX_W'(w) == upd_way_i) begin
          valid_q[set_i][w] <= 1'b1;
          tag_q[set_i][w]   <= upd_tag_i;
          age_q[set_i][w]   <= '0;
        end else if (age_q[set_i][w] != AGE_MAX) begin
          age_q[set_i][w] <= age_q[set_i][w] + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/cht_stat_counters.sv
module cht_stat_counters
  import cht_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fire_i,
  input  cht_result_t       result_i,
  output logic [CNT_W-1:0]  hit_count_o,
  output logic [CNT_W-1:0]  miss_count_o,
  output logic [CNT_W-1:0]  evict_count_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_count_o   <= '0;
      miss_count_o  <= '0;
      evict_count_o <= '0;
    end else if (fire_i) begin
      if (result_i.hit)   hit_count_o   <= hit_count_o + 1'b1;
      if (result_i.miss)  miss_count_o  <= miss_count_o + 1'b1;
      if (result_i.evict) evict_count_o <= evict_count_o + 1'b1;
    end
  end

endmodule

// File: rtl/cache_hit_tracker.sv
module cache_hit_tracker
  import cht_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int SET_BITS    = 2,
  parameter int OFFSET_BITS = 4,
  parameter int WAYS        = 4,
  parameter int AGE_W       = $clog2(WAYS) + 1,
  parameter int CNT_W       = 32,
  localparam int TAG_W      = ADDR_W - SET_BITS - OFFSET_BITS,
  localparam int WAY_IDX_W  = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              rsp_valid_o,
  output logic              rsp_hit_o,
  output logic              rsp_miss_o,
  output logic              rsp_evict_o,
  output logic [CNT_W-1:0]  hit_count_o,
  output logic [CNT_W-1:0]  miss_count_o,
  output logic [CNT_W-1:0]  evict_count_o
);

  logic [TAG_W-1:0]           key_tag;
  logic [SET_BITS-1:0]        key_set;
  logic [WAYS-1:0]            set_valid;
  logic [WAYS-1:0][TAG_W-1:0] set_tag;
  logic [WAYS-1:0][AGE_W-1:0] set_age;
  logic [WAY_IDX_W-1:0]       target_way;
  cht_result_t                lookup;
  logic                       fire;

  assign req_ready_o = 1'b1;
  assign fire        = req_valid_i & req_ready_o;

  cht_addr_split #(
    .ADDR_W      (ADDR_W),
    .SET_BITS    (SET_BITS),
    .OFFSET_BITS (OFFSET_BITS)
  ) i_split (
    .addr_i (req_addr_i),
    .tag_o  (key_tag),
    .set_o  (key_set)
  );

  cht_line_store #(
    .SET_BITS (SET_BITS),
    .WAYS     (WAYS),
    .TAG_W    (TAG_W),
    .AGE_W    (AGE_W)
  ) i_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (key_set),
    .rd_valid_o (set_valid),
    .rd_tag_o   (set_tag),
    .rd_age_o   (set_age),
    .upd_i      (fire),
    .upd_way_i  (target_way),
    .upd_tag_i  (key_tag)
  );

  cht_way_select #(
    .WAYS  (WAYS),
    .TAG_W (TAG_W),
    .AGE_W (AGE_W)
  ) i_select (
    .valid_i  (set_valid),
    .tag_i    (set_tag),
    .age_i    (set_age),
    .key_i    (key_tag),
    .target_o (target_way),
    .result_o (lookup)
  );

  cht_stat_counters #(
    .CNT_W (CNT_W)
  ) i_stats (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .fire_i        (fire),
    .result_i      (lookup),
    .hit_count_o   (hit_count_o),
    .miss_count_o  (miss_count_o),
    .evict_count_o (evict_count_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_hit_o   <= 1'b0;
      rsp_miss_o  <= 1'b0;
      rsp_evict_o <= 1'b0;
    end else begin
      rsp_valid_o <= fire;
      rsp_hit_o   <= fire & lookup.hit;
      rsp_miss_o  <= fire & lookup.miss;
      rsp_evict_o <= fire & lookup.evict;
    end
  end

endmodule

// File: rtl/cht_checker.sv
module cht_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_ready_o,
  input logic             rsp_valid_o,
  input logic             rsp_hit_o,
  input logic             rsp_miss_o,
  input logic             rsp_evict_o,
  input logic [CNT_W-1:0] hit_count_o,
  input logic [CNT_W-1:0] miss_count_o,
  input logic [CNT_W-1:0] evict_count_o
);

  // R4
  evict_implies_miss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_evict_o |-> rsp_miss_o);

  // R4
  one_of_hit_miss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (rsp_hit_o ^ rsp_miss_o));

  // R8
  rsp_after_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> rsp_valid_o);

  // R8
  no_rsp_without_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_valid_i && req_ready_o) |=> !rsp_valid_o);

  // R8
  idle_flags_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> !(rsp_hit_o || rsp_miss_o || rsp_evict_o));

  // R10
  hit_count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_count_o == $past(hit_count_o) + CNT_W'(rsp_hit_o));

  // R10
  miss_count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_count_o == $past(miss_count_o) + CNT_W'(rsp_miss_o));

  // R10
  evict_count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evict_count_o == $past(evict_count_o) + CNT_W'(rsp_evict_o));

endmodule

bind cache_hit_tracker cht_checker #(.CNT_W(CNT_W)) i_cht_checker (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_valid_i   (req_valid_i),
  .req_ready_o   (req_ready_o),
  .rsp_valid_o   (rsp_valid_o),
  .rsp_hit_o     (rsp_hit_o),
  .rsp_miss_o    (rsp_miss_o),
  .rsp_evict_o   (rsp_evict_o),
  .hit_count_o   (hit_count_o),
  .miss_count_o  (miss_count_o),
  .evict_count_o (evict_count_o)
);

// File: tb/test_cache_hit_tracker.sv
`timescale 1ns/1ps
module test_cache_hit_tracker;

  localparam int NSETS = 4;
  localparam int MAXW  = 4;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid = 1'b0;
  logic [15:0] req_addr = '0;

  logic        rdy [2];
  logic        rv [2], rh [2], rm [2], re [2];
  logic [31:0] hc [2], mc [2], ec [2];

  always #5 clk_i = ~clk_i;

  cache_hit_tracker #(
    .ADDR_W(16), .SET_BITS(2), .OFFSET_BITS(4), .WAYS(4), .AGE_W(3), .CNT_W(32)
  ) i_cache_hit_tracker (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_ready_o(rdy[0]),
    .req_addr_i(req_addr), .rsp_valid_o(rv[0]), .rsp_hit_o(rh[0]), .rsp_miss_o(rm[0]),
    .rsp_evict_o(re[0]), .hit_count_o(hc[0]), .miss_count_o(mc[0]), .evict_count_o(ec[0])
  );

  cache_hit_tracker #(
    .ADDR_W(16), .SET_BITS(2), .OFFSET_BITS(4), .WAYS(1), .AGE_W(1), .CNT_W(32)
  ) i_cache_hit_tracker_dm (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_ready_o(rdy[1]),
    .req_addr_i(req_addr), .rsp_valid_o(rv[1]), .rsp_hit_o(rh[1]), .rsp_miss_o(rm[1]),
    .rsp_evict_o(re[1]), .hit_count_o(hc[1]), .miss_count_o(mc[1]), .evict_count_o(ec[1])
  );

  // behavioural reference state, [instance][set][way]
  bit       m_valid [2][NSETS][MAXW];
  int       m_tag   [2][NSETS][MAXW];
  int       m_age   [2][NSETS][MAXW];
  int       m_hits [2], m_miss [2], m_evs [2];
  bit       exp_v;
  bit       exp_h [2], exp_m [2], exp_e [2];
  string    pend_tag;
  int       n_cmp = 0;
  int       n_bad = 0;
  bit       done = 1'b0;

  task automatic ck(input string tg, input string what, input logic [31:0] act,
                    input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tg, what, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < 2; i++) begin
      for (int s = 0; s < NSETS; s++)
        for (int w = 0; w < MAXW; w++) begin
          m_valid[i][s][w] = 1'b0; m_tag[i][s][w] = 0; m_age[i][s][w] = 0;
        end
      m_hits[i] = 0; m_miss[i] = 0; m_evs[i] = 0;
      exp_h[i] = 0; exp_m[i] = 0; exp_e[i] = 0;
    end
    exp_v = 1'b0;
  endtask

  task automatic model_access(input int i, input int ways, input int agemax,
                              input logic [15:0] a);
    int tg, st, tgt;
    bit hit, free;
    tg = int'(a[15:6]);
    st = int'(a[5:4]);
    hit = 0; free = 0; tgt = 0;
    for (int w = 0; w < ways; w++)
      if (!hit && m_valid[i][st][w] && m_tag[i][st][w] == tg) begin hit = 1; tgt = w; end
    if (!hit)
      for (int w = 0; w < ways; w++)
        if (!free && !m_valid[i][st][w]) begin free = 1; tgt = w; end
    if (!hit && !free) begin
      tgt = 0;
      for (int w = 1; w < ways; w++)
        if (m_age[i][st][w] > m_age[i][st][tgt]) tgt = w;
    end
    for (int w = 0; w < ways; w++)
      if (m_age[i][st][w] < agemax) m_age[i][st][w]++;
    m_age[i][st][tgt]   = 0;
    m_valid[i][st][tgt] = 1'b1;
    m_tag[i][st][tgt]   = tg;
    exp_h[i] = hit;
    exp_m[i] = !hit;
    exp_e[i] = !hit && !free;
    if (hit) m_hits[i]++; else m_miss[i]++;
    if (exp_e[i]) m_evs[i]++;
  endtask

  task automatic check_pending();
    for (int i = 0; i < 2; i++) begin
      string tg;
      tg = (i == 1) ? "R7" : pend_tag;
      ck((i == 1) ? "R7" : "R8", "rsp_valid", rv[i], exp_v);
      ck((i == 1) ? "R7" : "R8", "req_ready", rdy[i], 1);
      ck(tg, "hit", rh[i], exp_v ? exp_h[i] : 0);
      ck(tg, "miss", rm[i], exp_v ? exp_m[i] : 0);
      ck((i == 1) ? "R7" : (pend_tag == "R2" ? "R4" : pend_tag), "evict", re[i],
         exp_v ? exp_e[i] : 0);
      ck((i == 1) ? "R7" : "R10", "hit_count", hc[i], m_hits[i]);
      ck((i == 1) ? "R7" : "R10", "miss_count", mc[i], m_miss[i]);
      ck((i == 1) ? "R7" : "R10", "evict_count", ec[i], m_evs[i]);
    end
  endtask

  // check previous result, then drive the next request
  task automatic step(input bit v, input logic [15:0] a, input string tg);
    @(negedge clk_i);
    check_pending();
    req_valid = v;
    req_addr  = a;
    pend_tag  = tg;
    exp_v     = v;
    if (v) begin
      model_access(0, 4, 7, a);
      model_access(1, 1, 1, a);
    end
  endtask

  function automatic logic [15:0] mk(input int tg, input int st, input int off);
    return {tg[9:0], st[1:0], off[3:0]};
  endfunction

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    req_valid = 1'b0;
    model_clear();
    pend_tag = "R9";
    @(negedge clk_i);
    check_pending();
    rst_ni = 1'b1;
  endtask

  initial begin
    int seed;
    seed = 32'h5eed_c0de;
    void'($urandom(seed));
    model_clear();
    pend_tag = "R9";
    repeat (2) @(negedge clk_i);
    // R9 reset state
    check_pending();
    rst_ni = 1'b1;

    // R1 offset ignored, set index selects set
    step(1, mk(1, 0, 0), "R9");
    step(1, mk(1, 0, 15), "R1");
    step(1, mk(1, 1, 7), "R1");
    step(1, mk(1, 1, 3), "R1");

    // R3 fill set 3 in way order, no eviction
    step(1, mk(1, 3, 0), "R3");
    step(1, mk(2, 3, 0), "R3");
    step(1, mk(3, 3, 0), "R3");
    step(1, mk(4, 3, 0), "R3");
    // R5 hit refreshes tag 1, so tag 2 becomes the victim
    step(1, mk(1, 3, 0), "R5");
    step(1, mk(5, 3, 0), "R4");
    step(1, mk(1, 3, 0), "R5");
    step(1, mk(2, 3, 0), "R6");

    // R6 saturation tie: fill set 2, hammer tag 4
    step(1, mk(1, 2, 0), "R3");
    step(1, mk(2, 2, 0), "R3");
    step(1, mk(3, 2, 0), "R3");
    step(1, mk(4, 2, 0), "R3");
    for (int k = 0; k < 10; k++) step(1, mk(4, 2, k), "R5");
    step(1, mk(9, 2, 0), "R6");
    step(1, mk(2, 2, 0), "R6");
    step(1, mk(3, 2, 0), "R6");
    step(1, mk(1, 2, 0), "R6");

    // R8 idle gaps between requests
    step(0, 16'h0, "R8");
    step(1, mk(9, 2, 1), "R8");
    step(0, 16'h0, "R8");
    step(0, 16'h0, "R8");

    // R9 reset mid-run, then first accesses miss
    do_reset();
    step(1, mk(9, 2, 1), "R9");
    step(1, mk(1, 3, 0), "R9");

    // random mix
    for (int k = 0; k < 3000; k++) begin
      bit v;
      v = ($urandom % 5) != 0;
      step(v, mk($urandom % 7, $urandom % 4, $urandom % 16), "R2");
    end
    step(0, 16'h0, "R8");
    step(0, 16'h0, "R8");

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule